// File: doc/BRIEF.md
# Partial Store Edge Mask Generator

This execution unit produces the element-enable mask for the first or last piece of a vector store that starts or ends part-way into an 8-byte aligned block. It takes two address operands: the first marks where the store begins and the second marks where it ends. A 4-bit selector picks the element width (byte, halfword or word) and the element ordering. From the low address bits of the first operand it forms a leading-edge mask. When both operands fall in the same aligned block, it ANDs that mask with a trailing-edge mask formed from the second operand. The result is zero-extended into a 64-bit destination.

The selector also picks between a variant that writes integer condition codes and a variant that leaves them alone. The condition codes are those of the subtraction first minus second, over the full 64 bits and over the low 32 bits. A narrow-address input limits the block comparison to the low 32 address bits. The unit registers its results, so they appear one clock after the operation is presented.

Top module: `edge_mask_unit`

## Requirements
- R1: Every operation presented with `op_valid` high produces `res_valid` high exactly one clock later; a cycle without `op_valid` produces `res_valid` low one clock later.
- R2: With selector bit 1 clear (big-endian ordering), the index is k = first address bits [2:w] and j = second address bits [2:w], where w is 0, 1 or 2 for width codes 0, 1 and 2 in selector bits [3:2]. The element count is n = 8 >> w and full = 2^n - 1. The leading mask is (full << k) truncated to n bits, and the trailing mask is full >> (n-1-j).
- R3: With selector bit 1 set (little-endian ordering), the leading mask is full >> k, and the trailing mask is (full << (n-1-j)) truncated to n bits.
- R4: Both operands have bits [2:0] cleared and are then compared. If they are equal, the mask is the leading mask AND the trailing mask; otherwise the mask is the leading mask alone.
- R5: When `narrow_addr` is high, only address bits [31:3] take part in that comparison, so operands that differ only above bit 31 count as the same block.
- R6: When selector bit 0 is clear and the width code is valid, `flags_wr` is high with the result. `flags64` holds {N,Z,V,C} (bit 3 down to bit 0) of the 64-bit subtraction first minus second, where C means an unsigned borrow.
- R7: `flags32` holds {N,Z,V,C} of the same subtraction over address bits [31:0], under the same conditions as R6.
- R8: When selector bit 0 is set, `flags_wr` stays low.
- R9: All bits of `mask_out` above the 8-bit mask field are always zero.
- R10: Width code 3 raises `bad_op` with the result, forces `mask_out` to zero and keeps `flags_wr` low.
- R11: In the clock after reset, `res_valid`, `mask_out`, `flags_wr`, `bad_op`, `flags64` and `flags32` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | [3:2] width code, [1] little-endian, [0] keep condition codes |
| addr_a | input | 64 | First (start) address operand |
| addr_b | input | 64 | Second (end) address operand |
| narrow_addr | input | 1 | Compare blocks on the low 32 address bits only |
| res_valid | output | 1 | Result registers hold a new result |
| mask_out | output | 64 | Zero-extended edge mask |
| flags_wr | output | 1 | Condition codes are to be written |
| flags64 | output | 4 | {N,Z,V,C} of the 64-bit subtraction |
| flags32 | output | 4 | {N,Z,V,C} of the 32-bit subtraction |
| bad_op | output | 1 | Reserved width code was selected |

## Verification
Some properties are checked on every cycle: the one-cycle valid timing, that the upper mask bits stay zero, that the keep-codes variant never writes flags, that a reserved width yields an error with an empty mask, and that equal operands in a writing variant report Z set and C clear. The mask values of each width and ordering, the choice between the AND and the leading-edge-only mask, the effect of narrow addressing and the N, V and C values are shown only by the bench. It sweeps every selector code against every pair of low address bits, for same-block, high-differing and block-differing operand pairs.

// File: rtl/edge_mask_pkg.sv
package edge_mask_pkg;

    localparam int ADDR_W     = 64;
    localparam int HALF_W     = ADDR_W / 2;
    localparam int BLK_BITS   = 3;
    localparam int MASK_W     = 1 << BLK_BITS;
    localparam int NUM_WIDTHS = 3;

    typedef enum logic [1:0] {
        ELEM_BYTE  = 2'd0,
        ELEM_HALF  = 2'd1,
        ELEM_WORD  = 2'd2,
        ELEM_RSVD  = 2'd3
    } elem_w_e;

    typedef struct packed {
        elem_w_e width;
        logic    little;
        logic    keep_cc;
        logic    bad;
    } edge_op_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    function automatic edge_op_t decode_sel(input logic [3:0] sel);
        edge_op_t d;
        d.width   = elem_w_e'(sel[3:2]);
        d.little  = sel[1];
        d.keep_cc = sel[0];
        d.bad     = (sel[3:2] == ELEM_RSVD);
        return d;
    endfunction

endpackage

// File: rtl/edge_mask_gen.sv
module edge_mask_gen
    import edge_mask_pkg::*;
#(
    parameter int BLK = BLK_BITS,
    parameter int NW  = NUM_WIDTHS
) (
    input  elem_w_e                width,
    input  logic                   little,
    input  logic [BLK-1:0]         first_lo,
    input  logic [BLK-1:0]         last_lo,
    output logic [(1<<BLK)-1:0]    lead_mask,
    output logic [(1<<BLK)-1:0]    trail_mask
);
    localparam int MW = 1 << BLK;

    logic [MW-1:0] lead_c  [NW];
    logic [MW-1:0] trail_c [NW];

    for (genvar w = 0; w < NW; w++) begin : g_width
        localparam int N = MW >> w;
        logic [BLK-1:0] fi, li;
        logic [MW-1:0]  be_lead, be_trail, le_lead, le_trail;

        always_comb begin
            fi       = first_lo >> w;
            li       = last_lo >> w;
            be_lead  = '0;
            be_trail = '0;
            le_lead  = '0;
            le_trail = '0;
            for (int e = 0; e < N; e++) begin
                be_lead[e]  = (e >= int'(fi));
                be_trail[e] = (e <= int'(li));
                le_lead[e]  = (e <= N - 1 - int'(fi));
                le_trail[e] = (e >= N - 1 - int'(li));
            end
        end

        assign lead_c[w]  = little ? le_lead  : be_lead;
        assign trail_c[w] = little ? le_trail : be_trail;
    end

    always_comb begin
        lead_mask  = '0;
        trail_mask = '0;
        for (int w = 0; w < NW; w++) begin
            if (int'(width) == w) begin
                lead_mask  = lead_c[w];
                trail_mask = trail_c[w];
            end
        end
    end

endmodule

// File: rtl/edge_block_match.sv
module edge_block_match #(
    parameter int DW  = 64,
    parameter int NWD = 32,
    parameter int BLK = 3
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          narrow,
    output logic          same_blk
);
    logic lo_eq, hi_eq;

    assign lo_eq    = (a[NWD-1:BLK] == b[NWD-1:BLK]);
    assign hi_eq    = (a[DW-1:NWD] == b[DW-1:NWD]);
    assign same_blk = lo_eq & (narrow | hi_eq);

endmodule

// File: rtl/edge_flag_calc.sv
module edge_flag_calc
    import edge_mask_pkg::*;
#(
    parameter int DW = ADDR_W
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output cc_t           cc_full,
    output cc_t           cc_half
);
    cc_t lane_cc [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int W = DW >> g;
        logic [W:0] diff;

        assign diff = {1'b0, a[W-1:0]} - {1'b0, b[W-1:0]};
        assign lane_cc[g].c = diff[W];
        assign lane_cc[g].n = diff[W-1];
        assign lane_cc[g].z = (diff[W-1:0] == '0);
        assign lane_cc[g].v = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
    end

    assign cc_full = lane_cc[0];
    assign cc_half = lane_cc[1];

endmodule

// File: rtl/edge_mask_unit.sv
module edge_mask_unit
    import edge_mask_pkg::*;
#(
    parameter int DATA_W = ADDR_W,
    parameter int NARROW = HALF_W,
    parameter int BLK    = BLK_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] addr_a,
    input  logic [DATA_W-1:0] addr_b,
    input  logic              narrow_addr,
    output logic              res_valid,
    output logic [DATA_W-1:0] mask_out,
    output logic              flags_wr,
    output logic [3:0]        flags64,
    output logic [3:0]        flags32,
    output logic              bad_op
);
    localparam int MW = 1 << BLK;

    edge_op_t      op;
    logic [MW-1:0] lead_m, trail_m, edge_m;
    logic          same_blk;
    cc_t           cc_full, cc_half;

    assign op = decode_sel(op_sel);

    edge_mask_gen #(.BLK(BLK), .NW(NUM_WIDTHS)) u_gen (
        .width      (op.width),
        .little     (op.little),
        .first_lo   (addr_a[BLK-1:0]),
        .last_lo    (addr_b[BLK-1:0]),
        .lead_mask  (lead_m),
        .trail_mask (trail_m)
    );

    edge_block_match #(.DW(DATA_W), .NWD(NARROW), .BLK(BLK)) u_match (
        .a        (addr_a),
        .b        (addr_b),
        .narrow   (narrow_addr),
        .same_blk (same_blk)
    );

    edge_flag_calc #(.DW(DATA_W)) u_flags (
        .a       (addr_a),
        .b       (addr_b),
        .cc_full (cc_full),
        .cc_half (cc_half)
    );

    always_comb begin
        if (op.bad)
            edge_m = '0;
        else if (same_blk)
            edge_m = lead_m & trail_m;
        else
            edge_m = lead_m;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            mask_out  <= '0;
            flags_wr  <= 1'b0;
            flags64   <= '0;
            flags32   <= '0;
            bad_op    <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                mask_out <= {{(DATA_W-MW){1'b0}}, edge_m};
                flags_wr <= ~op.keep_cc & ~op.bad;
                flags64  <= cc_full;
                flags32  <= cc_half;
                bad_op   <= op.bad;
            end else begin
                flags_wr <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/edge_mask_unit_chk.sv
module edge_mask_unit_chk #(
    parameter int DATA_W = 64,
    parameter int MW     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] addr_a,
    input logic [DATA_W-1:0] addr_b,
    input logic              res_valid,
    input logic [DATA_W-1:0] mask_out,
    input logic              flags_wr,
    input logic [3:0]        flags64,
    input logic              bad_op
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R1
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);

    // R8
    keep_cc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel[0]) |=> !flags_wr);

    // R10
    rsvd_width_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel[3:2] == 2'b11) |=> (bad_op && !flags_wr && mask_out == '0));

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (mask_out[DATA_W-1:MW] == '0));

    // R6
    equal_ops_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_sel[0] && op_sel[3:2] != 2'b11 && addr_a == addr_b)
        |=> (flags_wr && flags64[2] && !flags64[0]));

    // R6
    wr_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        flags_wr |-> res_valid);
endmodule

bind edge_mask_unit edge_mask_unit_chk #(.DATA_W(DATA_W), .MW(1 << BLK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .addr_a    (addr_a),
    .addr_b    (addr_b),
    .res_valid (res_valid),
    .mask_out  (mask_out),
    .flags_wr  (flags_wr),
    .flags64   (flags64),
    .bad_op    (bad_op)
);

// File: tb/edge_mask_unit_test.sv
module edge_mask_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_sel;
    logic [63:0] addr_a, addr_b;
    logic        narrow_addr;
    logic        res_valid, flags_wr, bad_op;
    logic [63:0] mask_out;
    logic [3:0]  flags64, flags32;

    int checks = 0;
    int fails  = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    edge_mask_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .addr_a(addr_a), .addr_b(addr_b), .narrow_addr(narrow_addr),
        .res_valid(res_valid), .mask_out(mask_out), .flags_wr(flags_wr),
        .flags64(flags64), .flags32(flags32), .bad_op(bad_op)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_cc(input logic [63:0] a, input logic [63:0] b, input int w);
        logic signed [64:0] sa, sb, sd;
        logic [63:0] ua, ub, ud;
        logic n, z, v, c;
        ua = (w == 64) ? a : {32'd0, a[31:0]};
        ub = (w == 64) ? b : {32'd0, b[31:0]};
        if (w == 64) begin
            sa = $signed({a[63], a});
            sb = $signed({b[63], b});
        end else begin
            sa = $signed({{33{a[31]}}, a[31:0]});
            sb = $signed({{33{b[31]}}, b[31:0]});
        end
        sd = sa - sb;
        ud = ua - ub;
        c  = (ua < ub);
        z  = (ua == ub);
        n  = (w == 64) ? ud[63] : ud[31];
        v  = (w == 64) ? (sd[64] != sd[63]) : (sd[32] != sd[31]);
        return {n, z, v, c};
    endfunction

    function automatic logic [7:0] ref_mask(input int sel, input int k8, input int j8, input bit same);
        int w, n, k, j;
        logic [8:0] full;
        logic [7:0] lead, trail;
        w = sel >> 2;
        if (w == 3) return 8'h00;
        n = 8 >> w;
        k = k8 >> w;
        j = j8 >> w;
        full = (9'd1 << n) - 9'd1;
        if (sel[1]) begin
            lead  = 8'(full >> k);
            trail = 8'(((full << (n - 1 - j)) & full));
        end else begin
            lead  = 8'(((full << k) & full));
            trail = 8'(full >> (n - 1 - j));
        end
        return same ? (lead & trail) : lead;
    endfunction

    task automatic run_op(input int sel, input int k, input int j, input int mode);
        logic [63:0] r, a, b;
        bit same;
        string mreq;
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
        r = lfsr * 64'h2545_F491_4F6C_DD1D;
        a = {r[63:3], 3'(k)};
        case (mode)
            0: begin b = {r[63:3], 3'(j)}; narrow_addr = 1'b0; same = 1; end
            1: begin b = {r[63:3] ^ 61'(64'd1 << 37), 3'(j)}; narrow_addr = 1'b0; same = 0; end
            2: begin b = {r[63:3] ^ 61'(64'd1 << 37), 3'(j)}; narrow_addr = 1'b1; same = 1; end
            default: begin b = {r[63:3] ^ 61'd1, 3'(j)}; narrow_addr = 1'b1; same = 0; end
        endcase
        op_sel   = 4'(sel);
        addr_a   = a;
        addr_b   = b;
        op_valid = 1'b1;
        @(negedge clk);
        if ((sel >> 2) == 3) mreq = "R10";
        else if (mode == 2) mreq = "R5";
        else if (mode != 0) mreq = "R4";
        else mreq = sel[1] ? "R3" : "R2";
        check("R1", 64'(res_valid), 64'd1);
        check(mreq, {56'd0, mask_out[7:0]}, {56'd0, ref_mask(sel, k, j, same)});
        check("R9", {8'd0, mask_out[63:8]}, 64'd0);
        check("R10", 64'(bad_op), 64'((sel >> 2) == 3));
        if (sel[0] || (sel >> 2) == 3) begin
            check("R8", 64'(flags_wr), 64'd0);
        end else begin
            check("R6", 64'(flags_wr), 64'd1);
            check("R6", 64'(flags64), 64'(ref_cc(a, b, 64)));
            check("R7", 64'(flags32), 64'(ref_cc(a, b, 32)));
        end
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_sel = '0;
        addr_a = '0; addr_b = '0; narrow_addr = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", {res_valid, flags_wr, bad_op, flags64, flags32}, 64'd0);
        check("R11", mask_out, 64'd0);
        rst = 1'b0;
        for (int sel = 0; sel < 16; sel++)
            for (int k = 0; k < 8; k++)
                for (int j = 0; j < 8; j++)
                    for (int mode = 0; mode < 4; mode++)
                        run_op(sel, k, j, mode);
        // R1: idle cycle drops res_valid and write enable
        op_valid = 1'b0;
        @(negedge clk);
        check("R1", 64'(res_valid), 64'd0);
        check("R6", 64'(flags_wr), 64'd0);
        // R6 boundary: borrow and overflow corner
        op_sel = 4'b0000; narrow_addr = 1'b0; op_valid = 1'b1;
        addr_a = 64'h8000_0000_0000_0000; addr_b = 64'd1;
        @(negedge clk);
        check("R6", 64'(flags64), 64'(ref_cc(64'h8000_0000_0000_0000, 64'd1, 64)));
        check("R7", 64'(flags32), 64'(ref_cc(64'h8000_0000_0000_0000, 64'd1, 32)));
        op_valid = 1'b0;
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule